// File: doc/BRIEF.md
# Background Tile Fetch and Shift Pipeline

This block turns a scroll position and the contents of video memory into a stream of 4-bit background palette indices, one per visible pixel of a 256-pixel line. Every 8 dots it reads four bytes through a simple synchronous read port: the tile number from the name area, the colour-group byte from the attribute area, and then the two bit-plane bytes of the tile's current row from the pattern area. The bytes wait in latches until the group ends. They are then loaded into four 16-bit shift registers, which move one position per dot. A 3-bit fine horizontal offset picks the tap that each pixel is read from.

The block keeps its own 15-bit position register. Bits [4:0] hold the coarse column, [9:5] the coarse row, bit 10 the horizontal name-area select, bit 11 the vertical name-area select, and [14:12] the row inside the tile. The column advances after each tile fetch. The row inside the tile advances once at the end of each line and carries into the coarse row. A frame-start pulse loads the whole register. A line-start pulse reloads only the horizontal part, so vertical progress carries over from one line to the next. Each start pulse runs 16 dots of prefetch (two tiles) followed by 256 output dots, and then the block goes idle.

Top module: `bg_tile_pipe`

## Requirements
- R1: While a line runs, the dot counter starts at 0 on the cycle after a start pulse. On dots 8k and 8k+1 the block fetches the name byte at 0x2000 | pos[11:0], on 8k+2/8k+3 the attribute byte, on 8k+4/8k+5 bit-plane 0, and on 8k+6/8k+7 bit-plane 1. memRd is high exactly on the even dots. memData carries the byte for the address of the previous cycle.
- R2: The pattern addresses are tableSel*0x1000 + tile*16 + rowInTile for plane 0, and the same plus 8 for plane 1. bgTableSel selects the table.
- R3: The attribute address is 0x23C0 | pos[11:10]<<10 | (coarseRow>>2)<<3 | (coarseCol>>2). The tile's 2-bit colour group is byte bits [2s+1:2s], with s = {coarseRow[1], coarseCol[1]}.
- R4: pixValid is high on dots 16 to 271 exactly, and pixX = dot-16. For pixel x, let p = x+fineX. The output comes from tile p/8 of the line at bit column p%8 (bit 7 is leftmost). The result is {group[1:0], plane1 bit, plane0 bit}. pixIdx is 0 whenever pixValid is low.
- R5: The coarse column increments after each 8-dot group. From 31 it wraps to 0 and toggles pos[10].
- R6: At the end of a line the row inside the tile increments. On overflow from 7 it becomes 0 and the coarse row advances: 29 wraps to 0 and toggles pos[11], 31 wraps to 0 without a toggle, and any other value increments.
- R7: frameStart loads all 15 position bits and the fine offset. lineStart loads only pos[4:0], pos[10] and the fine offset.
- R8: With showBg at 0, pixIdx is 0.
- R9: With showLeft at 0, pixIdx is 0 for pixels 0 to 7.
- R10: A pixel whose two plane bits are both 0 outputs index 0, whatever its colour group.
- R11: During reset memRd, pixValid and pixIdx are 0.
- R12: A start pulse in the middle of a line restarts the line from dot 0. It takes priority over the column step and the end-of-line step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Start a line and reload the horizontal position |
| frameStart | input | 1 | Start a line and load the full position |
| scrollIn | input | 15 | Position source for the loads |
| fineXIn | input | 3 | Fine horizontal offset source |
| bgTableSel | input | 1 | Pattern table select (0x0000 or 0x1000) |
| showBg | input | 1 | Background enable |
| showLeft | input | 1 | Background enable for pixels 0 to 7 |
| memRd | output | 1 | Read strobe |
| memAddr | output | 14 | Read address |
| memData | input | 8 | Read data, one cycle after the address |
| pixValid | output | 1 | Pixel output valid |
| pixX | output | 8 | Pixel column |
| pixIdx | output | 4 | Background palette index |

## Verification
The hardest cases to reach are the two vertical wraps, because they happen only at a line end after the row inside the tile has reached 7. The stimulus reaches them by loading a frame position with coarse row 29 or 31 and row-in-tile 6 or 7, then running one or two whole lines. It then checks the name address fetched on the first dot of the next line. Mid-line column wrap is reached with a start column of 27 and a non-zero fine offset, so the tiles on either side of the name-area seam share one shifter window. A restart pulse at dot 100 covers line abandonment.

// File: rtl/bg_tile_pkg.sv
package bg_tile_pkg;
  localparam int TILE_W = 8;
  localparam int POS_W  = 15;
  localparam int ADDR_W = 14;

  typedef struct packed {
    logic       loadAll;
    logic       loadH;
    logic       latchTile;
    logic       latchAttr;
    logic       latchLo;
    logic       reload;
    logic       tileStep;
    logic       lineEnd;
    logic       shiftEn;
    logic [1:0] fetchSel;
  } ctrl_t;
endpackage

// File: rtl/bg_tile_ctrl.sv
module bg_tile_ctrl
  import bg_tile_pkg::*;
#(
  parameter int LINE_PIXELS    = 256,
  parameter int PREFETCH_TILES = 2,
  localparam int XW            = $clog2(LINE_PIXELS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineStart,
  input  logic          frameStart,
  output ctrl_t         ctrl,
  output logic          memRd,
  output logic          pixValid,
  output logic [XW-1:0] pixX
);
  localparam int PRE_DOTS = PREFETCH_TILES * TILE_W;
  localparam int LAST     = PRE_DOTS + LINE_PIXELS - 1;
  localparam int DW       = $clog2(LAST + 1);

  logic [DW-1:0] dot;
  logic          busy;
  logic [2:0]    phase;

  assign phase = dot[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      dot  <= '0;
    end else if (lineStart || frameStart) begin
      busy <= 1'b1;
      dot  <= '0;
    end else if (busy) begin
      if (dot == DW'(LAST)) begin
        busy <= 1'b0;
        dot  <= '0;
      end else begin
        dot <= dot + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.loadAll   = frameStart;
    ctrl.loadH     = lineStart & ~frameStart;
    ctrl.latchTile = busy && (phase == 3'd1);
    ctrl.latchAttr = busy && (phase == 3'd3);
    ctrl.latchLo   = busy && (phase == 3'd5);
    ctrl.reload    = busy && (phase == 3'd7);
    ctrl.tileStep  = busy && (phase == 3'd7);
    ctrl.lineEnd   = busy && (dot == DW'(LAST));
    ctrl.shiftEn   = busy;
    ctrl.fetchSel  = phase[2:1];
  end

  assign memRd    = busy & ~phase[0];
  assign pixValid = busy && (dot >= DW'(PRE_DOTS));
  assign pixX     = XW'(dot - DW'(PRE_DOTS));
endmodule

// File: rtl/bg_tile_dp.sv
module bg_tile_dp
  import bg_tile_pkg::*;
#(
  parameter int XW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [POS_W-1:0]  scrollIn,
  input  logic [2:0]        fineXIn,
  input  logic              bgTableSel,
  input  logic              showBg,
  input  logic              showLeft,
  input  logic              pixValid,
  input  logic [XW-1:0]     pixX,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        pixIdx,
  output logic [POS_W-1:0]  vCur
);
  logic [POS_W-1:0] pos, posNext;
  logic [2:0]       fineX;
  logic [7:0]       tileLatch, loLatch, attrShifted;
  logic [1:0]       attrBits;
  logic [15:0]      shPat [2];
  logic [15:0]      shAt  [2];
  logic [7:0]       patIn [2];
  logic [3:0]       tap;
  logic [1:0]       patVal, grpVal;

  // position stepping: column per tile, row at line end
  always_comb begin
    posNext = pos;
    if (ctrl.tileStep) begin
      if (pos[4:0] == 5'd31) begin
        posNext[4:0] = 5'd0;
        posNext[10]  = ~pos[10];
      end else begin
        posNext[4:0] = pos[4:0] + 5'd1;
      end
    end
    if (ctrl.lineEnd) begin
      if (pos[14:12] != 3'd7) begin
        posNext[14:12] = pos[14:12] + 3'd1;
      end else begin
        posNext[14:12] = 3'd0;
        if (pos[9:5] == 5'd29) begin
          posNext[9:5] = 5'd0;
          posNext[11]  = ~pos[11];
        end else if (pos[9:5] == 5'd31) begin
          posNext[9:5] = 5'd0;
        end else begin
          posNext[9:5] = pos[9:5] + 5'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos   <= '0;
      fineX <= '0;
    end else if (ctrl.loadAll) begin
      pos   <= scrollIn;
      fineX <= fineXIn;
    end else if (ctrl.loadH) begin
      pos[4:0] <= scrollIn[4:0];
      pos[10]  <= scrollIn[10];
      fineX    <= fineXIn;
    end else begin
      pos <= posNext;
    end
  end

  assign attrShifted = memData >> {pos[6], pos[1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileLatch <= '0;
      attrBits  <= '0;
      loLatch   <= '0;
    end else begin
      if (ctrl.latchTile) tileLatch <= memData;
      if (ctrl.latchAttr) attrBits  <= attrShifted[1:0];
      if (ctrl.latchLo)   loLatch   <= memData;
    end
  end

  // plane 1 goes straight from the read port into its shifter
  assign patIn[0] = loLatch;
  assign patIn[1] = memData;

  for (genvar i = 0; i < 2; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shPat[i] <= '0;
        shAt[i]  <= '0;
      end else if (ctrl.shiftEn) begin
        if (ctrl.reload) begin
          shPat[i] <= {shPat[i][14:7], patIn[i]};
          shAt[i]  <= {shAt[i][14:7], {8{attrBits[i]}}};
        end else begin
          shPat[i] <= {shPat[i][14:0], 1'b0};
          shAt[i]  <= {shAt[i][14:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    unique case (ctrl.fetchSel)
      2'd0:    memAddr = {2'b10, pos[11:0]};
      2'd1:    memAddr = {2'b10, pos[11:10], 4'b1111, pos[9:7], pos[4:2]};
      2'd2:    memAddr = {1'b0, bgTableSel, tileLatch, 1'b0, pos[14:12]};
      default: memAddr = {1'b0, bgTableSel, tileLatch, 1'b1, pos[14:12]};
    endcase
  end

  assign tap    = 4'd15 - {1'b0, fineX};
  assign patVal = {shPat[1][tap], shPat[0][tap]};
  assign grpVal = {shAt[1][tap], shAt[0][tap]};

  assign pixIdx = (pixValid && showBg && (showLeft || pixX >= XW'(TILE_W)) && patVal != 2'b00)
                  ? {grpVal, patVal} : 4'd0;
  assign vCur   = pos;
endmodule

// File: rtl/bg_tile_pipe.sv
module bg_tile_pipe
  import bg_tile_pkg::*;
#(
  parameter int LINE_PIXELS    = 256,
  parameter int PREFETCH_TILES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic [POS_W-1:0]  scrollIn,
  input  logic [2:0]        fineXIn,
  input  logic              bgTableSel,
  input  logic              showBg,
  input  logic              showLeft,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              pixValid,
  output logic [7:0]        pixX,
  output logic [3:0]        pixIdx
);
  localparam int XW = $clog2(LINE_PIXELS);

  ctrl_t            ctrl;
  logic [XW-1:0]    xPos;
  logic [POS_W-1:0] vCur;

  bg_tile_ctrl #(.LINE_PIXELS(LINE_PIXELS), .PREFETCH_TILES(PREFETCH_TILES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .ctrl(ctrl), .memRd(memRd), .pixValid(pixValid), .pixX(xPos)
  );

  bg_tile_dp #(.XW(XW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .scrollIn(scrollIn), .fineXIn(fineXIn),
    .bgTableSel(bgTableSel), .showBg(showBg), .showLeft(showLeft),
    .pixValid(pixValid), .pixX(xPos), .memData(memData),
    .memAddr(memAddr), .pixIdx(pixIdx), .vCur(vCur)
  );

  assign pixX = 8'(xPos);
endmodule

// File: rtl/bg_tile_chk.sv
module bg_tile_chk (
  input logic       clk,
  input logic       rstN,
  input logic       loadAny,
  input logic       memRd,
  input logic       pixValid,
  input logic [3:0] pixIdx,
  input logic       showBg,
  input logic       tileStep,
  input logic       lineEnd,
  input logic [4:0] coarseX,
  input logic [2:0] fineY
);
  AST_RD_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !loadAny) |=> !memRd); // R1
  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (pixIdx == 4'd0)); // R4
  AST_CX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tileStep && !loadAny) |=> (coarseX == $past(coarseX) + 5'd1)); // R5
  AST_FY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lineEnd && !loadAny) |=> (fineY == $past(fineY) + 3'd1)); // R6
  AST_BG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !showBg |-> (pixIdx == 4'd0)); // R8
  AST_BACKDROP: assert property (@(posedge clk) disable iff (!rstN)
    (pixIdx[1:0] == 2'b00) |-> (pixIdx[3:2] == 2'b00)); // R10
endmodule

bind bg_tile_pipe bg_tile_chk u_chk (
  .clk(clk), .rstN(rstN), .loadAny(lineStart | frameStart),
  .memRd(memRd), .pixValid(pixValid), .pixIdx(pixIdx), .showBg(showBg),
  .tileStep(ctrl.tileStep), .lineEnd(ctrl.lineEnd),
  .coarseX(vCur[4:0]), .fineY(vCur[14:12])
);

// File: tb/bg_tile_pipe_bench.sv
`timescale 1ns/1ps
module bg_tile_pipe_bench;
  localparam int PRE  = 16;
  localparam int LAST = PRE + 256 - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0, frameStart = 1'b0;
  logic [14:0] scrollIn = '0;
  logic [2:0]  fineXIn = '0;
  logic        bgTableSel = 1'b0, showBg = 1'b1, showLeft = 1'b1;
  logic        memRd, pixValid;
  logic [13:0] memAddr;
  logic [7:0]  memData = '0;
  logic [7:0]  pixX;
  logic [3:0]  pixIdx;

  int checks = 0, errors = 0;

  logic        mBusy = 1'b0;
  int          mDot = 0;
  logic [14:0] mV = '0, lineV0 = '0;
  int          lineFx = 0;

  always #2 clk = ~clk;

  bg_tile_pipe u_bg_tile_pipe (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .scrollIn(scrollIn), .fineXIn(fineXIn), .bgTableSel(bgTableSel),
    .showBg(showBg), .showLeft(showLeft), .memRd(memRd), .memAddr(memAddr),
    .memData(memData), .pixValid(pixValid), .pixX(pixX), .pixIdx(pixIdx)
  );

  function automatic int memFn(input int a);
    int h;
    h = a * 97 + (a >> 4) * 13 + 41;
    return (h ^ (h >> 7)) & 255;
  endfunction

  always @(posedge clk) memData <= 8'(memFn(int'(memAddr)));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns raw plane pair in bits 5:4, expected index in bits 3:0
  function automatic int expPix(input int x);
    int px, k, b, hc, ntH, tcx, cy, ntV, fy, ntA, tile, atA, sh, ab, pa, lo, hi, p, idx;
    px = x + lineFx; k = px >> 3; b = px & 7;
    hc = int'(lineV0[4:0]) + k;
    ntH = int'(lineV0[10]) ^ (hc >= 32 ? 1 : 0);
    tcx = hc % 32;
    cy = int'(lineV0[9:5]); ntV = int'(lineV0[11]); fy = int'(lineV0[14:12]);
    ntA = 'h2000 + ntV * 'h800 + ntH * 'h400 + cy * 32 + tcx;
    tile = memFn(ntA);
    atA = 'h23C0 + ntV * 'h800 + ntH * 'h400 + (cy / 4) * 8 + tcx / 4;
    sh = ((cy / 2) % 2) * 4 + ((tcx / 2) % 2) * 2;
    ab = (memFn(atA) >> sh) & 3;
    pa = int'(bgTableSel) * 'h1000 + tile * 16 + fy;
    lo = memFn(pa); hi = memFn(pa + 8);
    p = ((hi >> (7 - b)) & 1) * 2 + ((lo >> (7 - b)) & 1);
    idx = (p == 0 || !showBg || (x < 8 && !showLeft)) ? 0 : ab * 4 + p;
    return p * 16 + idx;
  endfunction

  function automatic int expAddr();
    int ntA;
    ntA = 'h2000 + int'(mV[11:0]);
    case ((mDot % 8) / 2)
      0: return ntA;
      1: return 'h23C0 + int'(mV[11]) * 'h800 + int'(mV[10]) * 'h400
                + (int'(mV[9:5]) / 4) * 8 + int'(mV[4:0]) / 4;
      2: return int'(bgTableSel) * 'h1000 + memFn(ntA) * 16 + int'(mV[14:12]);
      default: return int'(bgTableSel) * 'h1000 + memFn(ntA) * 16 + int'(mV[14:12]) + 8;
    endcase
  endfunction

  task automatic modelEdge();
    int cx, cy, fy;
    if (frameStart || lineStart) begin
      if (frameStart) mV = scrollIn;
      else begin mV[4:0] = scrollIn[4:0]; mV[10] = scrollIn[10]; end
      lineFx = int'(fineXIn); lineV0 = mV; mBusy = 1'b1; mDot = 0;
    end else if (mBusy) begin
      if (mDot % 8 == 7) begin
        cx = int'(mV[4:0]) + 1;
        if (cx == 32) begin cx = 0; mV[10] = ~mV[10]; end
        mV[4:0] = 5'(cx);
      end
      if (mDot == LAST) begin
        fy = int'(mV[14:12]) + 1; cy = int'(mV[9:5]);
        if (fy == 8) begin
          fy = 0;
          if (cy == 29) begin cy = 0; mV[11] = ~mV[11]; end
          else if (cy == 31) cy = 0;
          else cy = cy + 1;
        end
        mV[14:12] = 3'(fy); mV[9:5] = 5'(cy);
        mBusy = 1'b0; mDot = 0;
      end else mDot++;
    end
  endtask

  task automatic compareNow();
    bit expRd, expValid;
    int e, x, ph;
    string tag;
    expRd = mBusy && (mDot % 2 == 0);
    chk(memRd === expRd, "R1 read strobe", int'(memRd), int'(expRd));
    if (expRd) begin
      ph = (mDot % 8) / 2;
      tag = (ph == 0) ? "R1 name address" : (ph == 1) ? "R3 attribute address" : "R2 pattern address";
      chk(memAddr === 14'(expAddr()), tag, int'(memAddr), expAddr());
    end
    expValid = mBusy && (mDot >= PRE);
    chk(pixValid === expValid, "R4 valid", int'(pixValid), int'(expValid));
    if (expValid) begin
      x = mDot - PRE;
      e = expPix(x);
      if (!showBg) tag = "R8 hidden";
      else if (x < 8 && !showLeft) tag = "R9 left column";
      else if ((e >> 4) == 0) tag = "R10 backdrop";
      else tag = "R4 pixel";
      chk(pixIdx === 4'(e & 15), tag, int'(pixIdx), e & 15);
      chk(pixX === 8'(x), "R4 column", int'(pixX), x);
    end else begin
      chk(pixIdx === 4'd0, "R4 idle index", int'(pixIdx), 0);
    end
  endtask

  task automatic tick();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    compareNow();
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic startFrame(input logic [14:0] v, input logic [2:0] fx);
    scrollIn = v; fineXIn = fx; frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
  endtask

  task automatic startLine();
    lineStart = 1'b1;
    tick();
    lineStart = 1'b0;
  endtask

  task automatic finishLine();
    runCycles(LAST + 3);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(memRd === 1'b0, "R11 reset read", int'(memRd), 0);
      chk(pixValid === 1'b0, "R11 reset valid", int'(pixValid), 0);
      chk(pixIdx === 4'd0, "R11 reset index", int'(pixIdx), 0);
    end
    rstN = 1'b1;
    runCycles(3);

    // plain frame, two lines
    startFrame({3'd0, 2'b00, 5'd0, 5'd0}, 3'd0);
    finishLine();
    startLine();
    finishLine();

    // seam crossing, fine offset, high table, vertical wrap
    bgTableSel = 1'b1;
    startFrame({3'd6, 2'b01, 5'd29, 5'd27}, 3'd5);
    runCycles(40);
    chk(memAddr === 14'h23A0, "R5 column wrap name address", int'(memAddr), 'h23A0);
    runCycles(LAST + 3 - 40);
    startLine();
    chk(memAddr === 14'h27BB, "R7 horizontal reload", int'(memAddr), 'h27BB);
    finishLine();
    startLine();
    chk(memAddr === 14'h2C1B, "R6 row 29 wrap toggles", int'(memAddr), 'h2C1B);
    finishLine();

    // masks
    bgTableSel = 1'b0;
    showLeft = 1'b0;
    startFrame({3'd3, 2'b10, 5'd5, 5'd9}, 3'd3);
    finishLine();
    showLeft = 1'b1; showBg = 1'b0;
    startLine();
    finishLine();
    showBg = 1'b1;

    // row 31 wraps without toggle
    startFrame({3'd7, 2'b00, 5'd31, 5'd0}, 3'd7);
    finishLine();
    startLine();
    chk(memAddr === 14'h2000, "R6 row 31 wrap no toggle", int'(memAddr), 'h2000);
    finishLine();

    // mid-line restart
    startFrame({3'd2, 2'b10, 5'd4, 5'd3}, 3'd1);
    runCycles(100);
    scrollIn = {3'd2, 2'b10, 5'd4, 5'd10}; fineXIn = 3'd6;
    startLine();
    chk(pixValid === 1'b0, "R12 restart clears valid", int'(pixValid), 0);
    chk(memAddr === 14'h288A, "R12 restart name address", int'(memAddr), 'h288A);
    finishLine();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule